// File: doc/BRIEF.md
# Audio sample width adapter

This block converts audio samples in both directions between a 32-bit bus-side data word and a 24-bit signed processing datapath. The inbound path takes a word whose meaningful part has a configurable width and turns it into a 24-bit sample. When the sample is narrower than 24 bits, it is widened by filling the low bits from its own magnitude bits, so that full scale on the bus stays full scale in the datapath. The outbound path takes a 24-bit signed sample and narrows it or widens it to a configurable output width inside a 32-bit word. The same fill rule applies in that direction.

Each path has its own 4-bit width code and its own valid/ready handshake. Each path holds its result in a single register stage, and every transfer carries exactly one sample. The width code of a path is applied to the sample accepted in the same cycle.

Top module: `sw_adapter`

## Requirements
- R1: After synchronous reset, `core_in_valid` and `out_valid` are both low.
- R2: Inbound, for width N of 24 or less, bits N-1:0 of `in_word` land in bits 23:24-N of `core_in_data`, with bit N-1 as the sign; bits 31:N of `in_word` have no effect.
- R3: Inbound, for N below 24, the 24-N low bits of `core_in_data` are filled, from the top down, with the sample's bits N-2 down to 0, and that sequence is repeated until every vacated bit is filled.
- R4: Inbound, for width 32, `core_in_data` equals bits 31:8 of `in_word`.
- R5: Outbound, for width N of 24 or less, `out_word[N-1:0]` is the 24-bit sample shifted right arithmetically by 24-N, and bits 31:N copy bit N-1.
- R6: Outbound, for width 32, `out_word` is the 24-bit sample in bits 31:8, with bits 22:15 of the sample in bits 7:0.
- R7: The width codes are 0=8, 1=10, 2=12, 3=14, 4=16, 5=18, 6=20, 7=24 and 8=32 bits. Codes 9 to 15 act as code 7.
- R8: A sample accepted on a path (valid and ready high at a rising edge) is presented at that path's output from the next cycle, one result per accepted sample, in order.
- R9: While a path's output is valid and its ready is low, the output stays valid with unchanged data, and the path's input ready is low.
- R10: The two paths work independently, and a stall on one path does not delay the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_code | input | 4 | Inbound width code |
| in_valid | input | 1 | Inbound bus word offered |
| in_ready | output | 1 | Inbound stage can accept |
| in_word | input | 32 | Inbound bus word |
| core_in_valid | output | 1 | Widened sample available to the datapath |
| core_in_ready | input | 1 | Datapath takes the widened sample |
| core_in_data | output | 24 | Widened 24-bit sample |
| out_code | input | 4 | Outbound width code |
| core_out_valid | input | 1 | Datapath sample offered |
| core_out_ready | output | 1 | Outbound stage can accept |
| core_out_data | input | 24 | 24-bit signed datapath sample |
| out_valid | output | 1 | Bus word available |
| out_ready | input | 1 | Bus side takes the word |
| out_word | output | 32 | Resized outbound word |

## Verification
The bench builds the block with its default widths: a 32-bit bus word, a 24-bit core sample and 4-bit width codes. At these sizes all nine widths and all seven unused codes can be reached on each path. The narrow widths of 8, 10 and 12 bits are the ones where the fill pattern has to repeat. The ready inputs on both sides are toggled by a pseudo-random pattern, so holds, back-to-back transfers and a stall on one path while the other keeps moving all occur alongside the hand-picked full-scale and ignored-upper-bit vectors.

// File: rtl/sw_pkg.sv
package sw_pkg;

    localparam int BUS_W    = 32;
    localparam int CORE_W   = 24;
    localparam int CODE_W   = 4;
    localparam int N_WIDTHS = 9;
    localparam int EXT_W    = BUS_W - CORE_W;

    typedef enum logic [CODE_W-1:0] {
        W8  = 4'd0,
        W10 = 4'd1,
        W12 = 4'd2,
        W14 = 4'd3,
        W16 = 4'd4,
        W18 = 4'd5,
        W20 = 4'd6,
        W24 = 4'd7,
        W32 = 4'd8
    } width_code_e;

    typedef logic [CORE_W-1:0] core_sample_t;
    typedef logic [BUS_W-1:0]  bus_word_t;

    // Bit width selected by table index
    function automatic int width_of(input int idx);
        case (idx)
            0: return 8;
            1: return 10;
            2: return 12;
            3: return 14;
            4: return 16;
            5: return 18;
            6: return 20;
            7: return 24;
            default: return 32;
        endcase
    endfunction

    // Map a raw code onto a table index; unused codes fall back to 24 bits
    function automatic logic [CODE_W-1:0] code_to_idx(input logic [CODE_W-1:0] code);
        if (code <= 4'(W32))
            return code;
        return 4'(W24);
    endfunction

endpackage

// File: rtl/sw_in_shaper.sv
module sw_in_shaper
    import sw_pkg::*;
(
    input  logic [CODE_W-1:0] code,
    input  bus_word_t         word,
    output core_sample_t      sample
);
    core_sample_t variant [N_WIDTHS];

    for (genvar g = 0; g < N_WIDTHS; g++) begin : g_width
        localparam int N = width_of(g);
        if (N == BUS_W) begin : g_trunc
            assign variant[g] = word[BUS_W-1 -: CORE_W];
        end else if (N == CORE_W) begin : g_exact
            assign variant[g] = word[CORE_W-1:0];
        end else begin : g_fill
            localparam int GAP = CORE_W - N;
            localparam int MAG = N - 1;
            localparam int REP = GAP / MAG + 1;
            logic [REP*MAG-1:0] pattern;
            assign pattern    = {REP{word[MAG-1:0]}};
            assign variant[g] = {word[N-1:0], pattern[REP*MAG-1 -: GAP]};
        end
    end

    assign sample = variant[code_to_idx(code)];
endmodule

// File: rtl/sw_out_shaper.sv
module sw_out_shaper
    import sw_pkg::*;
(
    input  logic [CODE_W-1:0] code,
    input  core_sample_t      sample,
    output bus_word_t         word
);
    bus_word_t variant [N_WIDTHS];

    for (genvar g = 0; g < N_WIDTHS; g++) begin : g_width
        localparam int N = width_of(g);
        if (N == BUS_W) begin : g_widen
            assign variant[g] = {sample, sample[CORE_W-2 -: EXT_W]};
        end else begin : g_narrow
            assign variant[g] = {{(BUS_W-N){sample[CORE_W-1]}}, sample[CORE_W-1 -: N]};
        end
    end

    assign word = variant[code_to_idx(code)];
endmodule

// File: rtl/sw_stage.sv
module sw_stage #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         i_valid,
    output logic         i_ready,
    input  logic [W-1:0] i_data,
    output logic         o_valid,
    input  logic         o_ready,
    output logic [W-1:0] o_data
);
    assign i_ready = !o_valid || o_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            o_valid <= 1'b0;
            o_data  <= '0;
        end else if (i_ready) begin
            o_valid <= i_valid;
            if (i_valid)
                o_data <= i_data;
        end
    end
endmodule

// File: rtl/sw_adapter.sv
module sw_adapter
    import sw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [CODE_W-1:0] in_code,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [BUS_W-1:0]  in_word,
    output logic              core_in_valid,
    input  logic              core_in_ready,
    output logic [CORE_W-1:0] core_in_data,
    input  logic [CODE_W-1:0] out_code,
    input  logic              core_out_valid,
    output logic              core_out_ready,
    input  logic [CORE_W-1:0] core_out_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [BUS_W-1:0]  out_word
);
    core_sample_t widened;
    bus_word_t    resized;

    sw_in_shaper u_in_shape (
        .code   (in_code),
        .word   (in_word),
        .sample (widened)
    );

    sw_stage #(.W(CORE_W)) u_in_stage (
        .clk     (clk),
        .rst     (rst),
        .i_valid (in_valid),
        .i_ready (in_ready),
        .i_data  (widened),
        .o_valid (core_in_valid),
        .o_ready (core_in_ready),
        .o_data  (core_in_data)
    );

    sw_out_shaper u_out_shape (
        .code   (out_code),
        .sample (core_out_data),
        .word   (resized)
    );

    sw_stage #(.W(BUS_W)) u_out_stage (
        .clk     (clk),
        .rst     (rst),
        .i_valid (core_out_valid),
        .i_ready (core_out_ready),
        .i_data  (resized),
        .o_valid (out_valid),
        .o_ready (out_ready),
        .o_data  (out_word)
    );
endmodule

// File: rtl/sw_adapter_checker.sv
module sw_adapter_checker
    import sw_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [CODE_W-1:0] in_code,
    input logic              in_valid,
    input logic              in_ready,
    input logic [BUS_W-1:0]  in_word,
    input logic              core_in_valid,
    input logic              core_in_ready,
    input logic [CORE_W-1:0] core_in_data,
    input logic [CODE_W-1:0] out_code,
    input logic              core_out_valid,
    input logic              core_out_ready,
    input logic              out_valid,
    input logic              out_ready,
    input logic [BUS_W-1:0]  out_word
);
    a_r1_reset_idle: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!core_in_valid && !out_valid));

    a_r8_in_latency: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> core_in_valid);

    a_r8_out_latency: assert property (@(posedge clk) disable iff (rst)
        (core_out_valid && core_out_ready) |=> out_valid);

    a_r9_in_hold: assert property (@(posedge clk) disable iff (rst)
        (core_in_valid && !core_in_ready) |=> (core_in_valid && $stable(core_in_data)));

    a_r9_out_hold: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_word)));

    a_r9_in_block: assert property (@(posedge clk) disable iff (rst)
        (core_in_valid && !core_in_ready) |-> !in_ready);

    a_r4_top_bits: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && in_code == 4'(W32)) |=> (core_in_data == $past(in_word[BUS_W-1 -: CORE_W])));

    a_r6_low_fill: assert property (@(posedge clk) disable iff (rst)
        (core_out_valid && core_out_ready && out_code == 4'(W32)) |=> (out_word[EXT_W-1:0] == out_word[BUS_W-2 -: EXT_W]));

    a_r5_sign_ext16: assert property (@(posedge clk) disable iff (rst)
        (core_out_valid && core_out_ready && out_code == 4'(W16)) |=> (out_word[31:16] == {16{out_word[15]}}));
endmodule

bind sw_adapter sw_adapter_checker u_chk (
    .clk            (clk),
    .rst            (rst),
    .in_code        (in_code),
    .in_valid       (in_valid),
    .in_ready       (in_ready),
    .in_word        (in_word),
    .core_in_valid  (core_in_valid),
    .core_in_ready  (core_in_ready),
    .core_in_data   (core_in_data),
    .out_code       (out_code),
    .core_out_valid (core_out_valid),
    .core_out_ready (core_out_ready),
    .out_valid      (out_valid),
    .out_ready      (out_ready),
    .out_word       (out_word)
);

// File: tb/sw_adapter_test.sv
`timescale 1ns/1ps
module sw_adapter_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  in_code = '0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_word = '0;
    logic        core_in_valid;
    logic        core_in_ready = 1'b0;
    logic [23:0] core_in_data;
    logic [3:0]  out_code = '0;
    logic        core_out_valid = 1'b0;
    logic        core_out_ready;
    logic [23:0] core_out_data = '0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [31:0] out_word;

    int total = 0;
    int bad = 0;
    bit in_done = 0;
    bit out_done = 0;
    bit stall_in = 0;
    bit stall_out = 0;

    logic [23:0] q_in_exp[$];
    string       q_in_tag[$];
    logic [31:0] q_out_exp[$];
    string       q_out_tag[$];

    always #2.5 clk = ~clk;

    sw_adapter uut (.*);

    function automatic int bits_for(input logic [3:0] c);
        int t[9] = '{8, 10, 12, 14, 16, 18, 20, 24, 32};
        if (c > 4'd8) return 24;
        return t[c];
    endfunction

    function automatic logic [23:0] model_in(input logic [31:0] w, input logic [3:0] c);
        int n = bits_for(c);
        logic [31:0] v;
        logic [23:0] r;
        if (n == 32) return w[31:8];
        v = w & ((32'd1 << n) - 1);
        r = 24'(v << (24 - n));
        for (int j = 0; j < 24 - n; j++)
            r[23 - n - j] = v[n - 2 - (j % (n - 1))];
        return r;
    endfunction

    function automatic logic [31:0] model_out(input logic [23:0] d, input logic [3:0] c);
        int n = bits_for(c);
        logic signed [31:0] s;
        if (n == 32) return {d, d[22:15]};
        s = {{8{d[23]}}, d};
        return s >>> (24 - n);
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic send_in(input logic [3:0] c, input logic [31:0] w, input string tag);
        bit rdy;
        @(negedge clk);
        in_code = c; in_word = w; in_valid = 1'b1;
        q_in_exp.push_back(model_in(w, c));
        q_in_tag.push_back(tag);
        do begin
            #1 rdy = in_ready;
            @(posedge clk);
            if (!rdy) @(negedge clk);
        end while (!rdy);
        @(negedge clk);
        in_valid = 1'b0;
        in_word = $urandom;
    endtask

    task automatic send_out(input logic [3:0] c, input logic [23:0] d, input string tag);
        bit rdy;
        @(negedge clk);
        out_code = c; core_out_data = d; core_out_valid = 1'b1;
        q_out_exp.push_back(model_out(d, c));
        q_out_tag.push_back(tag);
        do begin
            #1 rdy = core_out_ready;
            @(posedge clk);
            if (!rdy) @(negedge clk);
        end while (!rdy);
        @(negedge clk);
        core_out_valid = 1'b0;
        core_out_data = 24'($urandom);
    endtask

    // Ready patterns on both consumer sides
    always @(negedge clk) begin
        if (!rst) begin
            core_in_ready <= stall_in ? 1'b0 : 1'($urandom % 3 != 0);
            out_ready     <= stall_out ? 1'b0 : 1'($urandom % 3 != 1);
        end
    end

    // Monitor: compare handshakes, check holds (R9)
    logic        p_in_hold = 0, p_out_hold = 0;
    logic [23:0] p_in_data;
    logic [31:0] p_out_data;
    always @(negedge clk) begin
        #1;
        if (!rst) begin
            if (p_in_hold) begin
                check("R9 inbound hold valid", 32'(core_in_valid), 32'd1);
                check("R9 inbound hold data", 32'(core_in_data), 32'(p_in_data));
            end
            if (p_out_hold) begin
                check("R9 outbound hold valid", 32'(out_valid), 32'd1);
                check("R9 outbound hold data", out_word, p_out_data);
            end
            if (core_in_valid && core_in_ready) begin
                if (q_in_exp.size() == 0) check("R8 inbound extra result", 32'd1, 32'd0);
                else check(q_in_tag.pop_front(), 32'(core_in_data), 32'(q_in_exp.pop_front()));
            end
            if (out_valid && out_ready) begin
                if (q_out_exp.size() == 0) check("R8 outbound extra result", 32'd1, 32'd0);
                else check(q_out_tag.pop_front(), out_word, q_out_exp.pop_front());
            end
            p_in_hold  = core_in_valid && !core_in_ready;
            p_in_data  = core_in_data;
            p_out_hold = out_valid && !out_ready;
            p_out_data = out_word;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        check("R1 inbound valid after reset", 32'(core_in_valid), 32'd0);
        check("R1 outbound valid after reset", 32'(out_valid), 32'd0);
        rst = 1'b0;
        fork
            begin
                send_in(4'd0, 32'h0000_0080, "R3 in 8-bit negative full scale");
                send_in(4'd0, 32'h0000_007F, "R3 in 8-bit positive full scale");
                send_in(4'd0, 32'hABCD_EF55, "R2 in upper bits ignored");
                send_in(4'd1, 32'h0000_02A5, "R3 in 10-bit repeat fill");
                send_in(4'd2, 32'hFFFF_F123, "R3 in 12-bit repeat fill");
                send_in(4'd4, 32'h0000_8001, "R2 in 16-bit");
                send_in(4'd7, 32'hFF12_3456, "R7 in 24-bit");
                send_in(4'd8, 32'h1234_5678, "R4 in 32-bit top bits");
                for (int c = 9; c < 16; c++)
                    send_in(4'(c), 32'h5A87_6543, "R7 in unused code as 24");
                for (int i = 0; i < 300; i++)
                    send_in(4'($urandom % 16), $urandom, "R2 R3 R10 in random");
                in_done = 1;
            end
            begin
                send_out(4'd8, 24'h80_0000, "R6 out 32-bit negative full scale");
                send_out(4'd8, 24'h7F_FFFF, "R6 out 32-bit positive full scale");
                send_out(4'd8, 24'h55_AA33, "R6 out 32-bit fill");
                send_out(4'd4, 24'h80_0000, "R5 out 16-bit sign extend");
                send_out(4'd0, 24'h7F_1234, "R5 out 8-bit");
                send_out(4'd7, 24'hC0_0001, "R7 out 24-bit");
                for (int c = 9; c < 16; c++)
                    send_out(4'(c), 24'h92_3456, "R7 out unused code as 24");
                // R10: inbound stalled, outbound must still drain
                stall_in = 1;
                send_out(4'd3, 24'h12_3456, "R10 out while inbound stalled");
                send_out(4'd5, 24'hF2_3456, "R10 out while inbound stalled");
                stall_in = 0;
                for (int i = 0; i < 300; i++)
                    send_out(4'($urandom % 16), 24'($urandom), "R5 R6 R10 out random");
                out_done = 1;
            end
        join
        wait (q_in_exp.size() == 0 && q_out_exp.size() == 0);
        repeat (3) @(posedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL R8 watchdog expired actual=pending expected=drained");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule